// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one parallel character at a time into an asynchronous serial frame on a single line. A set of static configuration inputs chooses whether the transmitter runs, how many data bits a character carries (7, 8 or 9), whether a parity bit is added and of which sense, and whether one or two stop bits close the frame. A character is offered on a valid/ready write port. When it is accepted, the transmitter sends a low start bit, then the data bits starting with the least significant, then the optional parity bit and the high stop bits. Each bit is held for sixteen pulses of an external bit-rate tick.

The ready output doubles as the transmit-ready request for an interrupt controller or a DMA engine. It is high whenever the transmitter is running and has no frame in progress. Dropping the enable clears the frame logic at once and silences the request. Raising the enable again brings the request back in the same cycle, because the transmitter starts out idle.

Top module: `uart_tx_core`

## Requirements
- R1: After reset with the enable high, the serial line is high and tx_ready is high. Whenever the transmitter is enabled and idle, the line stays high.
- R2: An accepted character produces a low start bit followed by the data bits, least significant bit first. Every bit lasts exactly 16 bit-rate ticks, counted from the clock edge that accepts the character.
- R3: Length code 0 sends 7 data bits, code 1 sends 8 and code 2 sends 9. The reserved code 3 sends 8.
- R4: With 9 data bits, data bit 8 follows data bit 7 and comes before any parity bit.
- R5: Parity code 2 appends a bit that makes the count of ones over the data bits and the parity bit even. Code 3 makes that count odd. Codes 0 and the reserved code 1 add no parity bit.
- R6: A stop-length input of 0 appends one high stop bit and 1 appends two. tx_ready returns high on the tick that completes the last stop bit, and the line then stays high.
- R7: tx_ready falls in the cycle after a character is accepted and stays low until the frame ends. tx_valid offered while tx_ready is low has no effect on the frame being sent.
- R8: The length, parity and stop settings and the data are captured when the character is accepted. Changes made to them during the frame do not alter it.
- R9: While the enable is low, tx_ready is low, tx_valid is ignored, and the line is high from the next clock edge on. A frame in progress is abandoned.
- R10: When the enable rises, tx_ready is high in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Transmitter enable; low holds the frame logic cleared |
| cfg_len | input | 2 | Data length code (0: 7, 1: 8, 2: 9, 3: treated as 8) |
| cfg_par | input | 2 | Parity code (0: none, 1: none, 2: even, 3: odd) |
| cfg_stop2 | input | 1 | 0: one stop bit, 1: two stop bits |
| bit_tick | input | 1 | Bit-rate tick, 16 pulses per bit |
| tx_valid | input | 1 | A character is offered |
| tx_data | input | 9 | Character; the upper bits beyond the chosen length are unused |
| tx_ready | output | 1 | Can accept a character; also the transmit-ready request |
| txd | output | 1 | Serial line, idle high |

## Verification
Directed frames cover every combination of the four length codes and the four parity codes with both stop settings. These separate a wrong length decode, a misplaced ninth bit, an inverted parity sense and a missing stop bit. Random characters with random settings then probe the data path with varied bit patterns. Some frames have their settings changed after acceptance or receive extra writes while busy, so that late capture or a leaky handshake shows up as a wrong bit. One run drops the enable partway through a frame. It checks the abort, that writes are ignored while disabled, and that ready comes back in the cycle the enable returns.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int MAX_DATA = 9;

  typedef enum logic [1:0] {
    LEN_7    = 2'd0,
    LEN_8    = 2'd1,
    LEN_9    = 2'd2,
    LEN_RSVD = 2'd3
  } len_code_e;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_RSVD = 2'd1,
    PAR_EVEN = 2'd2,
    PAR_ODD  = 2'd3
  } par_code_e;

  // number of data bits for a length code; the reserved code falls back to 8
  function automatic int data_bits(logic [1:0] code);
    case (code)
      LEN_7:   return 7;
      LEN_9:   return 9;
      default: return 8;
    endcase
  endfunction

endpackage

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int FRAME_W = 1 + MAX_DATA + 1 + 2,
  parameter int BITS_W  = $clog2(FRAME_W + 1)
) (
  input  logic [MAX_DATA-1:0] data,
  input  logic [1:0]          len,
  input  logic [1:0]          par,
  input  logic                stop2,
  output logic [FRAME_W-1:0]  frame,
  output logic [BITS_W-1:0]   nbits
);

  int   n_data;
  int   total;
  logic par_on;
  logic ones;

  always_comb begin
    n_data = data_bits(len);
    par_on = (par == PAR_EVEN) || (par == PAR_ODD);
    ones   = 1'b0;
    frame  = '1;          // unused tail positions stay at stop level
    frame[0] = 1'b0;      // start bit
    for (int i = 0; i < MAX_DATA; i++) begin
      if (i < n_data) begin
        frame[1 + i] = data[i];
        ones         = ones ^ data[i];
      end
    end
    for (int j = 0; j < FRAME_W; j++) begin
      if (par_on && (j == 1 + n_data)) begin
        frame[j] = ones ^ (par == PAR_ODD);
      end
    end
    total = 1 + n_data + (par_on ? 1 : 0) + (stop2 ? 2 : 1);
    nbits = BITS_W'(total);
  end

endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer #(
  parameter int FRAME_W       = 13,
  parameter int BITS_W        = $clog2(FRAME_W + 1),
  parameter int TICKS_PER_BIT = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               tick,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic [BITS_W-1:0]  nbits,
  output logic               txd,
  output logic               busy
);

  localparam int CNT_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(TICKS_PER_BIT - 1);

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   tcnt;
  logic [BITS_W-1:0]  left;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      shreg <= '1;
      tcnt  <= '0;
      left  <= '0;
      busy  <= 1'b0;
    end else if (load) begin
      shreg <= frame;
      tcnt  <= '0;
      left  <= nbits;
      busy  <= 1'b1;
    end else if (busy && tick) begin
      if (tcnt == LAST_TICK) begin
        tcnt  <= '0;
        shreg <= {1'b1, shreg[FRAME_W-1:1]};
        left  <= left - BITS_W'(1);
        if (left == BITS_W'(1)) busy <= 1'b0;
      end else begin
        tcnt <= tcnt + CNT_W'(1);
      end
    end
  end

  assign txd = shreg[0];

  AST_LINE_HIGH_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |=> txd);                                                    // R9
  AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
    (load && en) |=> !txd);                                          // R2
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (en && busy && !tick && !load) |=> $stable(txd));                // R2
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (en && !busy && !load) |=> txd);                                 // R1

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_en,
  input  logic [1:0]          cfg_len,
  input  logic [1:0]          cfg_par,
  input  logic                cfg_stop2,
  input  logic                bit_tick,
  input  logic                tx_valid,
  input  logic [MAX_DATA-1:0] tx_data,
  output logic                tx_ready,
  output logic                txd
);

  localparam int FRAME_W = 1 + MAX_DATA + 1 + 2;
  localparam int BITS_W  = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frame;
  logic [BITS_W-1:0]  nbits;
  logic               busy;
  logic               load;

  uart_tx_framer #(
    .FRAME_W (FRAME_W),
    .BITS_W  (BITS_W)
  ) i_framer (
    .data  (tx_data),
    .len   (cfg_len),
    .par   (cfg_par),
    .stop2 (cfg_stop2),
    .frame (frame),
    .nbits (nbits)
  );

  uart_tx_serializer #(
    .FRAME_W       (FRAME_W),
    .BITS_W        (BITS_W),
    .TICKS_PER_BIT (TICKS_PER_BIT)
  ) i_ser (
    .clk   (clk),
    .rst   (rst),
    .en    (cfg_en),
    .tick  (bit_tick),
    .load  (load),
    .frame (frame),
    .nbits (nbits),
    .txd   (txd),
    .busy  (busy)
  );

  assign tx_ready = cfg_en && !busy;
  assign load     = tx_valid && tx_ready;

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && cfg_en) |=> !tx_ready);                 // R7
  AST_READY_ON_ENABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_en) |-> tx_ready);                                     // R10
  AST_NO_READY_OFF: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |-> !tx_ready);                                          // R9

endmodule

// File: tb/test_uart_tx_core.sv
module test_uart_tx_core;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_en = 1'b1;
  logic [1:0] cfg_len = 2'd1;
  logic [1:0] cfg_par = 2'd0;
  logic       cfg_stop2 = 1'b0;
  logic       bit_tick = 1'b0;
  logic       tx_valid = 1'b0;
  logic [8:0] tx_data = '0;
  logic       tx_ready;
  logic       txd;

  int n_cmp = 0;
  int n_bad = 0;
  int tick_seen = 0;
  int tdiv = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_tx_core i_uart_tx_core (
    .clk       (clk),
    .rst       (rst),
    .cfg_en    (cfg_en),
    .cfg_len   (cfg_len),
    .cfg_par   (cfg_par),
    .cfg_stop2 (cfg_stop2),
    .bit_tick  (bit_tick),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_ready  (tx_ready),
    .txd       (txd)
  );

  // tick every third clock, changed away from the active edge
  always @(negedge clk) begin
    tdiv     = (tdiv == 2) ? 0 : tdiv + 1;
    bit_tick <= (tdiv == 2);
  end

  always @(posedge clk) if (bit_tick) tick_seen <= tick_seen + 1;

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  function automatic int bench_len(input logic [1:0] l);
    return (l == 2'd0) ? 7 : (l == 2'd2) ? 9 : 8;
  endfunction

  function automatic logic [12:0] exp_frame(input logic [8:0] d, input logic [1:0] l,
                                            input logic [1:0] p, input logic s, output int nb);
    logic [12:0] v;
    int n;
    bit pon;
    logic x;
    n   = bench_len(l);
    pon = p[1];
    v   = '1;
    v[0] = 1'b0;
    x   = 1'b0;
    for (int i = 0; i < n; i++) begin
      v[1 + i] = d[i];
      x = x ^ d[i];
    end
    if (pon) v[1 + n] = (p == 2'd3) ? ~x : x;
    nb = 1 + n + (pon ? 1 : 0) + (s ? 2 : 1);
    return v;
  endfunction

  task automatic wait_ticks(input int base, input int t);
    while (tick_seen - base < t) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input logic [1:0] l, input logic [1:0] p,
                      input logic s, input bit mid_cfg, input bit poke);
    logic [12:0] ev;
    int nb;
    int n;
    int base;
    string tag;
    ev = exp_frame(d, l, p, s, nb);
    n  = bench_len(l);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    cfg_len = l; cfg_par = p; cfg_stop2 = s; tx_data = d; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    base = tick_seen;
    chk("R7", tx_ready, 1'b0, "ready after accept");
    if (mid_cfg) begin
      cfg_len = 2'($urandom); cfg_par = 2'($urandom);
      cfg_stop2 = 1'($urandom); tx_data = 9'($urandom);
    end
    for (int k = 0; k < nb; k++) begin
      wait_ticks(base, 16 * k + 8);
      if (k == 0) tag = "R2 start";
      else if (k == 9 && n == 9) tag = "R4 ninth";
      else if (k <= n) tag = "R2 data";
      else if (k == n + 1 && p[1]) tag = "R5 parity";
      else tag = "R6 stop";
      if (mid_cfg) tag = {tag, " R8"};
      chk(tag, txd, ev[k], $sformatf("bit %0d d=%h len=%0d par=%0d s=%0b", k, d, l, p, s));
      if (poke && k == 1) begin
        tx_valid = 1'b1; tx_data = ~d;
      end
      if (poke && k == 2) chk("R7", tx_ready, 1'b0, "ready while busy");
      if (poke && k == 3) tx_valid = 1'b0;
    end
    wait_ticks(base, 16 * nb - 1);
    chk("R3 R6", tx_ready, 1'b0, "ready one tick before end");
    wait_ticks(base, 16 * nb);
    chk("R3 R6", tx_ready, 1'b1, "ready at frame end");
    chk("R1", txd, 1'b1, "line idle after frame");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", tx_ready, 1'b1, "ready after reset");
    chk("R1", txd, 1'b1, "line after reset");

    // directed: every length and parity code with both stop settings
    for (int l = 0; l < 4; l++)
      for (int p = 0; p < 4; p++)
        send(9'h1A5 ^ 9'(l * 37 + p), 2'(l), 2'(p), 1'((l + p) & 1), 1'b0, 1'b0);
    send(9'h100, 2'd2, 2'd2, 1'b1, 1'b0, 1'b0);   // R4 ninth bit alone set
    send(9'h0FF, 2'd2, 2'd3, 1'b0, 1'b0, 1'b0);   // R4 ninth bit clear
    send(9'h000, 2'd0, 2'd3, 1'b1, 1'b0, 1'b0);   // R5 odd parity on zero

    // random mix, some with late setting changes or busy writes
    for (int r = 0; r < 30; r++)
      send(9'($urandom), 2'($urandom), 2'($urandom), 1'($urandom),
           (r % 3) == 1, (r % 4) == 2);

    // disable partway through a frame
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    cfg_len = 2'd1; cfg_par = 2'd2; cfg_stop2 = 1'b0; tx_data = 9'h0AA; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (60) @(negedge clk);
    cfg_en = 1'b0;
    #1 chk("R9", tx_ready, 1'b0, "ready when disabled");
    @(negedge clk);
    chk("R9", txd, 1'b1, "line after disable");
    tx_valid = 1'b1; tx_data = 9'h000;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk("R9", txd, 1'b1, "line while disabled with valid");
      chk("R9", tx_ready, 1'b0, "ready while disabled with valid");
    end
    tx_valid = 1'b0;
    @(negedge clk);
    cfg_en = 1'b1;
    #1 chk("R10", tx_ready, 1'b1, "ready on re-enable");
    send(9'h03C, 2'd0, 2'd2, 1'b1, 1'b0, 1'b0);    // R10 works after re-enable

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule